// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor's sequencer and decides, every clock, whether an exception must be entered. It watches an external core reset pin, an external memory-abort pin, two active-low interrupt pins, and three requests raised inside the core: prefetch abort, undefined instruction and software interrupt. When more than one is pending it picks a single winner by fixed priority. It then issues a one-cycle entry command: the processor mode to switch to, the vector address to fetch from, a strobe to copy the current status into the saved status of the new mode, a strobe to write the return address into that mode's link register, and the new values of the two interrupt-disable bits.

The two interrupt pins may change at any time and are brought into the clock domain first. The fast interrupt uses one flop and the normal interrupt uses two. Both are masked by the disable bits of the current status. Reset and data abort act in any cycle. All other exceptions wait for the instruction-boundary strobe. While the core reset pin is low the core is held. When the pin is released, a supervisor-mode reset entry follows.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After the block reset `rst_n` is released with `ext_rst_n` high, `core_hold` is 1 and `entry_valid` is 0 for two rising edges. On the third rising edge a reset entry appears and `core_hold` falls to 0.
- R2: At most one entry is issued per cycle. When several requests are eligible together, the winner is chosen in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: The fast interrupt pin `fiq_n` passes through one synchronizing flop. If it goes low with `insn_bnd` high and `cur_f` low, no entry appears on the first rising edge and the entry appears on the second.
- R4: The normal interrupt pin `irq_n` passes through two synchronizing flops. Under the same conditions, with `cur_i` low, its entry appears on the third rising edge and not before.
- R5: While `cur_f` is 1, a low `fiq_n` causes no entry. While `cur_i` is 1, a low `irq_n` causes no entry.
- R6: Once a low level on `ext_rst_n` has passed two synchronizing flops, no entry is issued. `core_hold` rises one edge later. After `ext_rst_n` returns high, the reset entry appears on the third rising edge.
- R7: Fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt are taken only in a cycle with `insn_bnd` high. A data abort (`abort_i` high) is taken in any cycle, one rising edge later.
- R8: Every entry drives `new_i` to 1. `new_f` is 1 for fast-interrupt and reset entries; for all other entries it equals `cur_f` in the decision cycle.
- R9: `save_psr_we` and `link_we` are 1 with every entry except the reset entry, for which both are 0.
- R10: Each entry carries a fixed mode and vector: reset 0x13 / 0x00, undefined 0x1B / 0x04, software interrupt 0x13 / 0x08, prefetch abort 0x17 / 0x0C, data abort 0x17 / 0x10, normal interrupt 0x12 / 0x18, fast interrupt 0x11 / 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ext_rst_n | input | 1 | External core reset pin, active low, asynchronous |
| abort_i | input | 1 | Data abort from the memory system, synchronous |
| fiq_n | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt request, active low, asynchronous |
| pabt_req | input | 1 | Prefetch abort of the instruction at the boundary |
| und_req | input | 1 | Undefined instruction at the boundary |
| swi_req | input | 1 | Software interrupt at the boundary |
| cur_i | input | 1 | Current normal-interrupt disable bit |
| cur_f | input | 1 | Current fast-interrupt disable bit |
| insn_bnd | input | 1 | Instruction boundary strobe |
| entry_valid | output | 1 | One-cycle entry command valid |
| entry_mode | output | 5 | Mode to enter |
| entry_vector | output | ADDR_W | Vector address |
| save_psr_we | output | 1 | Copy current status to saved status |
| link_we | output | 1 | Write return address to link register |
| new_i | output | 1 | New normal-interrupt disable bit |
| new_f | output | 1 | New fast-interrupt disable bit |
| core_hold | output | 1 | Core held in reset |

## Verification
Each result is due a fixed number of rising edges after its stimulus. Data abort and boundary requests are due one edge later. The fast interrupt is due two edges later and the normal interrupt three. A reset entry is due three edges after release, and the hold flag rises three edges after the pin falls. The bench drives inputs just after a falling edge and samples just after the next falling edge. It checks the cycles before each due edge for absence of an entry, and the due cycle for the full command. Priority is walked one level at a time by retiring the previous winner between edges.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_SRC = 7;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = 8;

  typedef enum logic [SRC_W-1:0] {
    SRC_RST  = 3'd0,
    SRC_DABT = 3'd1,
    SRC_FIQ  = 3'd2,
    SRC_IRQ  = 3'd3,
    SRC_PABT = 3'd4,
    SRC_UND  = 3'd5,
    SRC_SWI  = 3'd6
  } exc_src_e;

  typedef enum logic [4:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B
  } cpu_mode_e;

  typedef struct packed {
    cpu_mode_e        mode;
    logic [VEC_W-1:0] vec;
    logic             save;
    logic             link;
    logic             set_f;
  } entry_cmd_t;

  function automatic cpu_mode_e mode_of(exc_src_e s);
    case (s)
      SRC_FIQ:            return MODE_FIQ;
      SRC_IRQ:            return MODE_IRQ;
      SRC_DABT, SRC_PABT: return MODE_ABT;
      SRC_UND:            return MODE_UND;
      default:            return MODE_SVC;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(exc_src_e s);
    case (s)
      SRC_UND:  return 8'h04;
      SRC_SWI:  return 8'h08;
      SRC_PABT: return 8'h0C;
      SRC_DABT: return 8'h10;
      SRC_IRQ:  return 8'h18;
      SRC_FIQ:  return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int NUM = 7,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   req,
  output logic [NUM-1:0]   grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  logic [NUM-1:0] higher;

  assign higher[0] = 1'b0;
  assign grant[0]  = req[0];

  generate
    for (genvar g = 1; g < NUM; g++) begin : g_level
      assign higher[g] = higher[g-1] | req[g-1];
      assign grant[g]  = req[g] & ~higher[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (grant[k]) idx = IDX_W'(k);
    end
  end

  assign any = |req;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ($countones(grant) == 1)); // R2

endmodule

// File: rtl/exc_entry_reg.sv
module exc_entry_reg
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  entry_cmd_t        cmd,
  output logic              valid,
  output logic [4:0]        mode,
  output logic [ADDR_W-1:0] vector,
  output logic              save_we,
  output logic              link_we,
  output logic              new_i,
  output logic              new_f
);

  logic              valid_q, valid_d;
  logic [4:0]        mode_q, mode_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              save_q, save_d;
  logic              link_q, link_d;
  logic              i_q, i_d;
  logic              f_q, f_d;

  always_comb begin
    valid_d = take;
    mode_d  = mode_q;
    vec_d   = vec_q;
    save_d  = save_q;
    link_d  = link_q;
    i_d     = i_q;
    f_d     = f_q;
    if (take) begin
      mode_d = cmd.mode;
      vec_d  = ADDR_W'(cmd.vec);
      save_d = cmd.save;
      link_d = cmd.link;
      i_d    = 1'b1;
      f_d    = cmd.set_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_SVC;
      vec_q   <= '0;
      save_q  <= 1'b0;
      link_q  <= 1'b0;
      i_q     <= 1'b0;
      f_q     <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mode_q  <= mode_d;
      vec_q   <= vec_d;
      save_q  <= save_d;
      link_q  <= link_d;
      i_q     <= i_d;
      f_q     <= f_d;
    end
  end

  assign valid   = valid_q;
  assign mode    = mode_q;
  assign vector  = vec_q;
  assign save_we = save_q;
  assign link_we = link_q;
  assign new_i   = i_q;
  assign new_f   = f_q;

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> i_q); // R8

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (save_q == link_q)); // R9

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIQ_STAGES = 1,
  parameter int IRQ_STAGES = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_n,
  input  logic              abort_i,
  input  logic              fiq_n,
  input  logic              irq_n,
  input  logic              pabt_req,
  input  logic              und_req,
  input  logic              swi_req,
  input  logic              cur_i,
  input  logic              cur_f,
  input  logic              insn_bnd,
  output logic              entry_valid,
  output logic [4:0]        entry_mode,
  output logic [ADDR_W-1:0] entry_vector,
  output logic              save_psr_we,
  output logic              link_we,
  output logic              new_i,
  output logic              new_f,
  output logic              core_hold
);

  logic fiq_s_n, irq_s_n, ext_rst_s_n;

  exc_sync #(.STAGES(FIQ_STAGES), .RST_VAL(1'b1)) u_fiq_sync (
    .clk(clk), .rst_n(rst_n), .d(fiq_n), .q(fiq_s_n));

  exc_sync #(.STAGES(IRQ_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s_n));

  exc_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(ext_rst_s_n));

  logic rst_pend_q, rst_pend_d;
  logic free;

  assign free = ext_rst_s_n & ~rst_pend_q;

  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [SRC_W-1:0]   win_idx;
  logic               win_any;

  always_comb begin
    req           = '0;
    req[SRC_RST]  = rst_pend_q & ext_rst_s_n;
    req[SRC_DABT] = free & abort_i;
    req[SRC_FIQ]  = free & insn_bnd & ~fiq_s_n & ~cur_f;
    req[SRC_IRQ]  = free & insn_bnd & ~irq_s_n & ~cur_i;
    req[SRC_PABT] = free & insn_bnd & pabt_req;
    req[SRC_UND]  = free & insn_bnd & und_req;
    req[SRC_SWI]  = free & insn_bnd & swi_req;
  end

  exc_prio_arb #(.NUM(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
    .idx(win_idx), .any(win_any));

  exc_src_e   win_src;
  entry_cmd_t cmd;

  always_comb begin
    win_src   = exc_src_e'(win_idx);
    cmd.mode  = mode_of(win_src);
    cmd.vec   = vec_of(win_src);
    cmd.save  = (win_src != SRC_RST);
    cmd.link  = (win_src != SRC_RST);
    cmd.set_f = (win_src == SRC_FIQ) | (win_src == SRC_RST) | cur_f;
  end

  always_comb begin
    rst_pend_d = (rst_pend_q | ~ext_rst_s_n) & ~grant[SRC_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pend_q <= 1'b1;
    else        rst_pend_q <= rst_pend_d;
  end

  assign core_hold = rst_pend_q;

  exc_entry_reg #(.ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .take(win_any), .cmd(cmd),
    .valid(entry_valid), .mode(entry_mode), .vector(entry_vector),
    .save_we(save_psr_we), .link_we(link_we),
    .new_i(new_i), .new_f(new_f));

  AST_NO_ENTRY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold |-> !entry_valid); // R6

  AST_FIQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_mode == MODE_FIQ) |-> !$past(cur_f)); // R5

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_mode == MODE_IRQ) |-> !$past(cur_i)); // R5

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_vector != ADDR_W'(8'h00) && entry_vector != ADDR_W'(8'h10))
      |-> $past(insn_bnd)); // R7

  AST_RESET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_vector == '0) |-> (!save_psr_we && !link_we && new_f)); // R9

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  localparam logic [4:0] M_FIQ = 5'h11;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_ABT = 5'h17;
  localparam logic [4:0] M_UND = 5'h1B;

  logic clk = 1'b0;
  logic rst_n, ext_rst_n, abort_i, fiq_n, irq_n;
  logic pabt_req, und_req, swi_req, cur_i, cur_f, insn_bnd;
  logic entry_valid, save_psr_we, link_we, new_i, new_f, core_hold;
  logic [4:0] entry_mode;
  logic [ADDR_W-1:0] entry_vector;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .abort_i(abort_i),
    .fiq_n(fiq_n), .irq_n(irq_n), .pabt_req(pabt_req), .und_req(und_req),
    .swi_req(swi_req), .cur_i(cur_i), .cur_f(cur_f), .insn_bnd(insn_bnd),
    .entry_valid(entry_valid), .entry_mode(entry_mode),
    .entry_vector(entry_vector), .save_psr_we(save_psr_we),
    .link_we(link_we), .new_i(new_i), .new_f(new_f), .core_hold(core_hold));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(string r, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    abort_i = 0; fiq_n = 1; irq_n = 1; pabt_req = 0; und_req = 0;
    swi_req = 0; insn_bnd = 0;
  endtask

  task automatic settle();
    quiet(); cur_i = 0; cur_f = 0;
    repeat (4) tick();
  endtask

  task automatic expect_none(string r);
    chk(r, "entry_valid", entry_valid, 0);
  endtask

  task automatic expect_entry(string r, logic [4:0] m, int vec, bit strobes, bit f);
    chk(r, "entry_valid", entry_valid, 1);
    chk("R10", "entry_mode", entry_mode, m);
    chk("R10", "entry_vector", entry_vector, vec);
    chk("R9", "save_psr_we", save_psr_we, strobes);
    chk("R9", "link_we", link_we, strobes);
    chk("R8", "new_i", new_i, 1);
    chk("R8", "new_f", new_f, f);
  endtask

  task automatic t_power_on();
    rst_n = 0; ext_rst_n = 1; cur_i = 0; cur_f = 0; quiet();
    repeat (3) tick();
    rst_n = 1;
    chk("R1", "core_hold", core_hold, 1);
    expect_none("R1");
    tick(); expect_none("R1");
    tick(); expect_none("R1");
    tick(); expect_entry("R1", M_SVC, 'h00, 0, 1);
    chk("R1", "core_hold", core_hold, 0);
    tick(); expect_none("R1");
  endtask

  task automatic t_fiq();
    fiq_n = 0; insn_bnd = 1;
    tick(); expect_none("R3");
    tick(); expect_entry("R3", M_FIQ, 'h1C, 1, 1);
    settle();
  endtask

  task automatic t_irq();
    irq_n = 0; insn_bnd = 1;
    tick(); expect_none("R4");
    tick(); expect_none("R4");
    tick(); expect_entry("R4", M_IRQ, 'h18, 1, 0);
    settle();
  endtask

  task automatic t_mask();
    cur_i = 1; cur_f = 1; fiq_n = 0; irq_n = 0; insn_bnd = 1;
    for (int k = 0; k < 4; k++) begin tick(); expect_none("R5"); end
    cur_f = 0;
    tick(); expect_entry("R5", M_FIQ, 'h1C, 1, 1);
    cur_f = 1;
    tick(); expect_none("R5");
    cur_i = 0;
    tick(); expect_entry("R5", M_IRQ, 'h18, 1, 1);
    settle();
  endtask

  task automatic t_boundary();
    pabt_req = 1; und_req = 1; swi_req = 1; insn_bnd = 0;
    tick(); expect_none("R7");
    tick(); expect_none("R7");
    abort_i = 1;
    tick(); expect_entry("R7", M_ABT, 'h10, 1, 0);
    abort_i = 0;
    tick(); expect_none("R7");
    settle();
  endtask

  task automatic t_priority();
    fiq_n = 0; irq_n = 0; insn_bnd = 0;
    repeat (3) begin tick(); expect_none("R2"); end
    insn_bnd = 1; abort_i = 1; pabt_req = 1; und_req = 1; swi_req = 1;
    tick(); expect_entry("R2", M_ABT, 'h10, 1, 0);
    abort_i = 0;
    tick(); expect_entry("R2", M_FIQ, 'h1C, 1, 1);
    cur_f = 1;
    tick(); expect_entry("R2", M_IRQ, 'h18, 1, 1);
    cur_i = 1;
    tick(); expect_entry("R2", M_ABT, 'h0C, 1, 1);
    pabt_req = 0;
    tick(); expect_entry("R2", M_UND, 'h04, 1, 1);
    und_req = 0;
    tick(); expect_entry("R2", M_SVC, 'h08, 1, 1);
    swi_req = 0;
    tick(); expect_none("R2");
    settle();
  endtask

  task automatic t_ext_reset();
    ext_rst_n = 0;
    repeat (3) tick();
    chk("R6", "core_hold", core_hold, 1);
    abort_i = 1; fiq_n = 0; pabt_req = 1; insn_bnd = 1;
    for (int k = 0; k < 3; k++) begin
      tick(); expect_none("R6");
      chk("R6", "core_hold", core_hold, 1);
    end
    quiet();
    ext_rst_n = 1;
    tick(); expect_none("R6");
    tick(); expect_none("R6");
    tick(); expect_entry("R6", M_SVC, 'h00, 0, 1);
    chk("R6", "core_hold", core_hold, 0);
    tick(); expect_none("R6");
    settle();
  endtask

  initial begin
    t_power_on();
    t_fiq();
    t_irq();
    t_mask();
    t_boundary();
    t_priority();
    t_ext_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule